// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block converts one request at a time (a command byte, an address byte, a data write or a data read) into the strobe and latch waveforms of a NAND flash bus. Three 3-bit fields set the timing in system clock cycles: the latch setup phase lasts exactly its field value, while the strobe low phase and the post-strobe hold phase each last their field value plus one. Requests enter through a valid/ready handshake and are held off while a cycle is in flight. The timing fields, the bus width bit and the operation kind are captured when a request is accepted.

Beside the cycle engine, the block passes a chip-select control bit straight to the chip-enable pin and gates all new cycles with a controller enable. It synchronises the ready/busy pin through two flops, watches for the edge picked by a select bit, and records it in a sticky flag. Software can clear that flag, and the flag can raise an interrupt.

Top module: `nand_cycle_gen`

## Requirements
- R1: After a request is accepted, a setup phase of exactly `cfg_setup` cycles precedes the strobe. During it the latch line of the operation is asserted and both strobes are high. A value of 0 skips the phase.
- R2: The strobe is low for exactly `cfg_active`+1 consecutive cycles. `nand_we_n` is used for command, address and write, and `nand_re_n` for read. The two strobes are never low together.
- R3: After the strobe rises, a hold phase of exactly `cfg_hold`+1 cycles follows. In it the strobes are high and the latch line and driven data stay as they were.
- R4: `busy` rises in the cycle after acceptance and stays high for `cfg_setup`+`cfg_active`+`cfg_hold`+2 cycles. `req_ready` is low whenever `busy` is high.
- R5: While `ctl_enable` is 0, `req_ready` is 0, no request is accepted and no strobe goes low.
- R6: `req_kind` encodes 0 as command, 1 as address, 2 as write and 3 as read. `nand_cle` is high for the whole of a command cycle only, and `nand_ale` for the whole of an address cycle only.
- R7: `nand_dq_oe` is high for the whole of command, address and write cycles and low during reads. Command and address bytes drive only bits [7:0], with the upper bits 0. Write data drives all 16 bits when the width bit `cfg_wide` is 1, and bits [7:0] only when it is 0.
- R8: A read samples `nand_dq_in` in the last strobe-low cycle. In the following cycle `rd_valid` pulses high for one cycle with the sample on `rd_data`. The upper 8 bits of `rd_data` are 0 when `cfg_wide` was 0.
- R9: `nand_ce_n` equals `ctl_ce_high` at all times (0 selects the chip).
- R10: `rb_flag` sets within 4 cycles of an edge on `nand_rb`. The edge is rising when `cfg_rb_fall` is 0 and falling when it is 1. The other edge is ignored, and the flag stays set.
- R11: A one-cycle pulse on `rb_flag_clr` clears `rb_flag`. `rb_irq` is high exactly when `rb_flag` and `ctl_rb_irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Controller enable; gates new cycles |
| ctl_ce_high | input | 1 | Chip-enable control bit |
| ctl_rb_irq_en | input | 1 | Lets the ready/busy flag raise the interrupt |
| cfg_setup | input | 3 | Latch setup cycles |
| cfg_active | input | 3 | Strobe low cycles minus one |
| cfg_hold | input | 3 | Hold cycles minus one |
| cfg_wide | input | 1 | 1 = 16-bit data path, 0 = 8-bit |
| cfg_rb_fall | input | 1 | Ready/busy edge select, 1 = falling |
| rb_flag_clr | input | 1 | Clears the sticky ready/busy flag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_kind | input | 2 | Operation kind |
| req_data | input | 16 | Command, address or write data |
| busy | output | 1 | Cycle in flight |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 16 | Captured read data |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_dq_out | output | 16 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus in |
| nand_rb | input | 1 | Ready/busy pin |
| rb_flag | output | 1 | Sticky ready/busy edge flag |
| rb_irq | output | 1 | Ready/busy interrupt |

## Verification
Each of the four operation kinds runs with its own timing triple. The triples include a zero setup, all-zero active and hold fields, and all fields at their maximum. Counting each phase separately shows whether an error comes from a missing offset, from an offset added where none belongs, or from a field applied to the wrong phase. Writes and reads run in both bus widths, which shows whether the upper-byte masking works. On the ready/busy pin the bench drives the edge that is not selected before the one that is, so a detector with the wrong polarity is exposed. Separate checks cover the clear and the interrupt gating.

// File: rtl/nand_cycle_pkg.sv
package nand_cycle_pkg;

    localparam int NCG_TIME_W = 3;
    localparam int NCG_DATA_W = 16;
    localparam int NCG_BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_WR   = 2'd2,
        OP_RD   = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    function automatic logic drives_bus(op_kind_e k);
        return k != OP_RD;
    endfunction

    function automatic logic full_width(op_kind_e k, logic wide);
        return wide && (k == OP_WR || k == OP_RD);
    endfunction

endpackage

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
    import nand_cycle_pkg::*;
#(
    parameter int TIME_W = NCG_TIME_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TIME_W-1:0] setup_cyc,
    input  logic [TIME_W-1:0] active_cyc,
    input  logic [TIME_W-1:0] hold_cyc,
    output phase_e            phase,
    output logic              last_active
);

    logic [TIME_W-1:0] cnt_q;
    logic [TIME_W-1:0] active_q;
    logic [TIME_W-1:0] hold_q;

    assign last_active = (phase == PH_ACTIVE) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt_q    <= '0;
            active_q <= '0;
            hold_q   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    active_q <= active_cyc;
                    hold_q   <= hold_cyc;
                    if (setup_cyc != '0) begin
                        phase <= PH_SETUP;
                        cnt_q <= setup_cyc - 1'b1;
                    end else begin
                        phase <= PH_ACTIVE;
                        cnt_q <= active_cyc;
                    end
                end
                PH_SETUP: if (cnt_q == '0) begin
                    phase <= PH_ACTIVE;
                    cnt_q <= active_q;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                PH_ACTIVE: if (cnt_q == '0) begin
                    phase <= PH_HOLD;
                    cnt_q <= hold_q;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                PH_HOLD: if (cnt_q == '0) begin
                    phase <= PH_IDLE;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nand_rb_detect.sv
module nand_rb_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rb_pin,
    input  logic sel_fall,
    input  logic flag_clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   edge_hit;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b1;
                else if (g == 0) sync_q[g] <= rb_pin;
                else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign edge_hit = sel_fall ? (prev_q && !sync_q[SYNC_STAGES-1])
                               : (!prev_q && sync_q[SYNC_STAGES-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            flag   <= 1'b0;
        end else begin
            prev_q <= sync_q[SYNC_STAGES-1];
            if (edge_hit) flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    assign irq = flag && irq_en;

endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
    import nand_cycle_pkg::*;
#(
    parameter int TIME_W = NCG_TIME_W,
    parameter int DATA_W = NCG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_enable,
    input  logic              ctl_ce_high,
    input  logic              ctl_rb_irq_en,
    input  logic [TIME_W-1:0] cfg_setup,
    input  logic [TIME_W-1:0] cfg_active,
    input  logic [TIME_W-1:0] cfg_hold,
    input  logic              cfg_wide,
    input  logic              cfg_rb_fall,
    input  logic              rb_flag_clr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_ce_n,
    output logic [DATA_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_in,
    input  logic              nand_rb,
    output logic              rb_flag,
    output logic              rb_irq
);

    localparam int UPPER_W = DATA_W - NCG_BYTE_W;

    phase_e            phase;
    logic              last_active;
    logic              accept;
    op_kind_e          kind_q;
    logic              wide_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] req_mask;
    logic [DATA_W-1:0] cap_mask;
    logic              strobe;

    assign busy      = (phase != PH_IDLE);
    assign req_ready = ctl_enable && !busy;
    assign accept    = req_valid && req_ready;
    assign req_mask  = {{UPPER_W{full_width(op_kind_e'(req_kind), cfg_wide)}},
                        {NCG_BYTE_W{1'b1}}};
    assign cap_mask  = {{UPPER_W{wide_q}}, {NCG_BYTE_W{1'b1}}};

    nand_phase_seq #(.TIME_W(TIME_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .setup_cyc  (cfg_setup),
        .active_cyc (cfg_active),
        .hold_cyc   (cfg_hold),
        .phase      (phase),
        .last_active(last_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q   <= OP_CMD;
            wide_q   <= 1'b0;
            data_q   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (accept) begin
                kind_q <= op_kind_e'(req_kind);
                wide_q <= cfg_wide;
                data_q <= req_data & req_mask;
            end
            rd_valid <= last_active && (kind_q == OP_RD);
            if (last_active && kind_q == OP_RD)
                rd_data <= nand_dq_in & cap_mask;
        end
    end

    assign strobe      = (phase == PH_ACTIVE);
    assign nand_cle    = busy && (kind_q == OP_CMD);
    assign nand_ale    = busy && (kind_q == OP_ADDR);
    assign nand_we_n   = !(strobe && drives_bus(kind_q));
    assign nand_re_n   = !(strobe && !drives_bus(kind_q));
    assign nand_dq_oe  = busy && drives_bus(kind_q);
    assign nand_dq_out = nand_dq_oe ? data_q : '0;
    assign nand_ce_n   = ctl_ce_high;

    nand_rb_detect #(.SYNC_STAGES(2)) u_rb (
        .clk     (clk),
        .rst     (rst),
        .rb_pin  (nand_rb),
        .sel_fall(cfg_rb_fall),
        .flag_clr(rb_flag_clr),
        .irq_en  (ctl_rb_irq_en),
        .flag    (rb_flag),
        .irq     (rb_irq)
    );

endmodule

// File: rtl/nand_cycle_chk.sv
module nand_cycle_chk (
    input logic clk,
    input logic rst,
    input logic ctl_enable,
    input logic ctl_rb_irq_en,
    input logic rb_flag_clr,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic rd_valid,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_dq_oe,
    input logic rb_flag,
    input logic rb_irq
);

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    p_strobe_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> busy);

    p_accept_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

    p_disable_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctl_enable && !busy) |=> !busy);

    p_latch_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    p_read_no_drive_r7: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !nand_dq_oe);

    p_rd_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(!nand_re_n) && nand_re_n));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (rb_flag && !rb_flag_clr) |=> rb_flag);

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
        rb_irq |-> (rb_flag && ctl_rb_irq_en));

endmodule

bind nand_cycle_gen nand_cycle_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctl_enable   (ctl_enable),
    .ctl_rb_irq_en(ctl_rb_irq_en),
    .rb_flag_clr  (rb_flag_clr),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .busy         (busy),
    .rd_valid     (rd_valid),
    .nand_cle     (nand_cle),
    .nand_ale     (nand_ale),
    .nand_we_n    (nand_we_n),
    .nand_re_n    (nand_re_n),
    .nand_dq_oe   (nand_dq_oe),
    .rb_flag      (rb_flag),
    .rb_irq       (rb_irq)
);

// File: tb/nand_cycle_gen_tb.sv
module nand_cycle_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_enable = 1'b0, ctl_ce_high = 1'b1, ctl_rb_irq_en = 1'b0;
    logic [2:0]  cfg_setup = '0, cfg_active = '0, cfg_hold = '0;
    logic        cfg_wide = 1'b0, cfg_rb_fall = 1'b0, rb_flag_clr = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_data = '0;
    logic        busy, rd_valid;
    logic [15:0] rd_data;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n;
    logic [15:0] nand_dq_out;
    logic        nand_dq_oe;
    logic [15:0] nand_dq_in = '0;
    logic        nand_rb = 1'b1;
    logic        rb_flag, rb_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    nand_cycle_gen u_dut (
        .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .ctl_ce_high(ctl_ce_high),
        .ctl_rb_irq_en(ctl_rb_irq_en), .cfg_setup(cfg_setup), .cfg_active(cfg_active),
        .cfg_hold(cfg_hold), .cfg_wide(cfg_wide), .cfg_rb_fall(cfg_rb_fall),
        .rb_flag_clr(rb_flag_clr), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_data(req_data), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
        .nand_rb(nand_rb), .rb_flag(rb_flag), .rb_irq(rb_irq)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Issues one request and measures each phase at the falling edges.
    task automatic run_op(input logic [1:0] kind, input logic [15:0] data, input logic wide,
                          input int s, input int a, input int h, input logic [15:0] din);
        int n_busy = 0, n_set = 0, n_act = 0, n_hold = 0;
        int n_cle = 0, n_ale = 0, n_oe = 0, n_rdv = 0, n_rdy = 0, n_wrong = 0;
        int n_hold_bad = 0;
        logic seen = 1'b0;
        logic [15:0] dq_seen = '0, rd_seen = '0;
        logic rd_op;
        rd_op = (kind == 2'd3);
        @(negedge clk);
        cfg_setup = 3'(s); cfg_active = 3'(a); cfg_hold = 3'(h);
        cfg_wide = wide; req_kind = kind; req_data = data; nand_dq_in = din;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_setup = 3'd0; cfg_active = 3'd0; cfg_hold = 3'd0; cfg_wide = ~wide;
        for (int k = 0; k < 64 && busy; k++) begin
            n_busy++;
            if (nand_cle) n_cle++;
            if (nand_ale) n_ale++;
            if (nand_dq_oe) n_oe++;
            if (req_ready) n_rdy++;
            if (rd_valid) begin n_rdv++; rd_seen = rd_data; end
            if ((rd_op ? nand_we_n : nand_re_n) == 1'b0) n_wrong++;
            if ((rd_op ? nand_re_n : nand_we_n) == 1'b0) begin
                n_act++; seen = 1'b1; dq_seen = nand_dq_out;
            end else if (!seen) n_set++;
            else begin
                n_hold++;
                if (!rd_op && nand_dq_out != dq_seen) n_hold_bad++;
            end
            @(negedge clk);
        end
        if (rd_valid) begin n_rdv++; rd_seen = rd_data; end
        check("R1 setup cycles", n_set, s);
        check("R2 strobe low cycles", n_act, a + 1);
        check("R2 other strobe idle", n_wrong, 0);
        check("R3 hold cycles", n_hold, h + 1);
        check("R3 data held in hold", n_hold_bad, 0);
        check("R4 busy length", n_busy, s + a + h + 2);
        check("R4 ready low while busy", n_rdy, 0);
        check("R6 cle cycles", n_cle, (kind == 2'd0) ? n_busy : 0);
        check("R6 ale cycles", n_ale, (kind == 2'd1) ? n_busy : 0);
        check("R7 drive enable cycles", n_oe, rd_op ? 0 : n_busy);
        if (rd_op) begin
            check("R8 rd_valid pulses", n_rdv, 1);
            check("R8 read data", rd_seen, wide ? din : {8'h00, din[7:0]});
        end else begin
            check("R7 driven data", dq_seen, (wide && kind == 2'd2) ? data : {8'h00, data[7:0]});
            check("R8 no rd_valid on write side", n_rdv, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R4 busy after reset", busy, 0);
        check("R5 ready with enable off", req_ready, 0);
        check("R2 we_n idle", nand_we_n, 1);
        check("R2 re_n idle", nand_re_n, 1);
        check("R6 latches idle", {nand_cle, nand_ale}, 0);
        check("R8 rd_valid idle", rd_valid, 0);
        check("R10 flag after reset", rb_flag, 0);
    endtask

    task automatic t_disabled();
        int strobes = 0, bz = 0, rdy = 0;
        ctl_enable = 1'b0;
        req_kind = 2'd2; req_data = 16'h1234; req_valid = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!nand_we_n || !nand_re_n) strobes++;
            if (busy) bz++;
            if (req_ready) rdy++;
        end
        req_valid = 1'b0;
        check("R5 no strobe when disabled", strobes, 0);
        check("R5 no busy when disabled", bz, 0);
        check("R5 ready low when disabled", rdy, 0);
        ctl_enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_ce();
        @(negedge clk); ctl_ce_high = 1'b0; #1;
        check("R9 ce low", nand_ce_n, 0);
        @(negedge clk); ctl_ce_high = 1'b1; #1;
        check("R9 ce high", nand_ce_n, 1);
    endtask

    task automatic t_rb();
        cfg_rb_fall = 1'b0; ctl_rb_irq_en = 1'b0;
        @(negedge clk); nand_rb = 1'b0;
        repeat (5) @(negedge clk);
        check("R10 falling ignored with rise select", rb_flag, 0);
        nand_rb = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 rising sets flag", rb_flag, 1);
        check("R11 irq masked", rb_irq, 0);
        nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 flag sticky", rb_flag, 1);
        ctl_rb_irq_en = 1'b1; #1;
        check("R11 irq enabled", rb_irq, 1);
        @(negedge clk); rb_flag_clr = 1'b1;
        @(negedge clk); rb_flag_clr = 1'b0;
        check("R11 flag cleared", rb_flag, 0);
        check("R11 irq follows flag", rb_irq, 0);
        cfg_rb_fall = 1'b1;
        nand_rb = 1'b1;
        repeat (5) @(negedge clk);
        check("R10 rising ignored with fall select", rb_flag, 0);
        nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 falling sets flag", rb_flag, 1);
        ctl_rb_irq_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_disabled();
        run_op(2'd0, 16'hAB70, 1'b1, 2, 1, 0, 16'h0);
        run_op(2'd1, 16'h5A12, 1'b1, 0, 0, 2, 16'h0);
        run_op(2'd2, 16'h5AC3, 1'b0, 1, 3, 1, 16'h0);
        run_op(2'd2, 16'h5AC3, 1'b1, 0, 0, 0, 16'h0);
        run_op(2'd3, 16'h0000, 1'b0, 3, 2, 0, 16'hBEEF);
        run_op(2'd3, 16'h0000, 1'b1, 7, 7, 7, 16'hBEEF);
        t_ce();
        t_rb();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule